// File: doc/BRIEF.md
# Gain-Normalising Averaging Decimator

This block takes a stream of raw 16-bit signed converter codes. Each code arrives with a one-bit tag that says which of two front-end gains was active when the code was taken. The high gain is one hundred times the low gain, so a code taken at the high gain stands for one hundredth of the input that the same code stands for at unity gain. The block brings every code onto the fine scale of the high gain: it multiplies unity-gain codes by 100 and passes high-gain codes through unchanged. It then adds them into a single wide signed accumulator.

After 72 accepted samples the block presents the undivided 72-sample sum as one 32-bit signed result, with a one-cycle valid pulse. The output rate is therefore the accepted input rate divided by 72; for example, 600 kS/s in gives about 8.33 kS/s out. The sum carries more resolution than any single 16-bit code, and a later stage may divide it or filter it further. A synchronous clear drops any partial block.

Top module: `gain_norm_decimator`

## Requirements
- R1: After reset, out_valid is 0 and out_result is 0.
- R2: A sample with in_gain_hi = 1 (the gain-100 setting) adds its signed 16-bit value unchanged. A sample with in_gain_hi = 0 (unity gain) adds its signed value multiplied by 100.
- R3: out_valid pulses high for exactly one cycle once every 72 accepted samples. The pulse appears in the cycle after the clock edge that accepts the 72nd sample.
- R4: During the pulse, out_result equals the signed sum of the 72 scaled samples of the block, as a 32-bit two's-complement word, and no overflow occurs.
- R5: The sample after the 72nd is the first sample of the next block, even when it arrives in the very next cycle. No sample is dropped at a block boundary.
- R6: A cycle with in_valid = 0 neither adds to the sum nor advances the sample count.
- R7: When clear is high at a clock edge, the count and the partial sum return to zero and no pulse is produced. A sample presented in the same cycle as clear is discarded.
- R8: out_result holds its last value in every cycle in which out_valid is low.
- R9: Blocks of full-scale codes at unity gain give exact sums: 72 x -32768 x 100 = -235929600 and 72 x 32767 x 100 = 235922400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of the partial block |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 16 | Raw converter code, two's complement |
| in_gain_hi | input | 1 | 1: sample taken at gain 100; 0: at unity gain |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 32 | Signed sum of the last 72 scaled samples |

## Verification
The embedded assertions check the following on every cycle:
- the count stays inside 0..71 and freezes on idle cycles;
- the count returns to zero after a wrap or a clear;
- every pulse stands alone and follows a counter wrap;
- the result holds between pulses;
- the running sum never exceeds the count times the largest scaled magnitude.

Only the bench scenarios can show that each sum equals the arithmetic value of the right 72 samples. The same holds for the correct scaling of each gain tag, for the start of the next block with no sample lost at a back-to-back boundary, and for the discard of the sample that coincides with a clear. The bench compares these against a model of the requirements. It mixes directed full-scale and single-gain blocks with random codes, gain tags, idle gaps and clears.

// File: rtl/gnd_pkg.sv
package gnd_pkg;
    localparam int SAMPLE_W_DEF = 16;
    localparam int RATIO_DEF    = 72;
    localparam int GAIN_DEF     = 100;
    localparam int SCALED_W_DEF = 24;
    localparam int ACC_W_DEF    = 32;

    typedef enum logic {
        GAIN_UNITY = 1'b0,
        GAIN_HIGH  = 1'b1
    } gain_sel_e;
endpackage

// File: rtl/gnd_scaler.sv
module gnd_scaler
    import gnd_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int SCALED_W = SCALED_W_DEF,
    parameter int GAIN     = GAIN_DEF
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                gain_hi,
    output logic [SCALED_W-1:0] scaled
);
    localparam logic signed [SCALED_W-1:0] FACTOR = SCALED_W'(GAIN);

    logic signed [SCALED_W-1:0] wide;
    logic signed [SCALED_W-1:0] product;

    always_comb begin
        wide    = {{(SCALED_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
        product = wide * FACTOR;
        if (gain_sel_e'(gain_hi) == GAIN_HIGH) begin
            scaled = wide;
        end else begin
            scaled = product;
        end
    end
endmodule

// File: rtl/gnd_block_counter.sv
module gnd_block_counter
    import gnd_pkg::*;
#(
    parameter int RATIO = RATIO_DEF,
    localparam int CNT_W = $clog2(RATIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = step && !clear && (s_q.cnt == LAST);
        if (clear) begin
            s_d.cnt = '0;
        end else if (step) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST); // R3
    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == '0); // R5
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(count)); // R6
    AST_CLEAR_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0); // R7
endmodule

// File: rtl/gnd_accum.sv
module gnd_accum
    import gnd_pkg::*;
#(
    parameter int SCALED_W = SCALED_W_DEF,
    parameter int ACC_W    = ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic             wrap,
    input  logic [SCALED_W-1:0] addend,
    output logic [ACC_W-1:0] acc,
    output logic             res_valid,
    output logic [ACC_W-1:0] result
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
        logic             vld;
    } acc_state_t;

    acc_state_t       s_d, s_q;
    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] sum;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        ext     = {{(ACC_W-SCALED_W){addend[SCALED_W-1]}}, addend};
        sum     = s_q.acc + ext;
        if (clear) begin
            s_d.acc = '0;
        end else if (add_en) begin
            if (wrap) begin
                s_d.res = sum;
                s_d.vld = 1'b1;
                s_d.acc = '0;
            end else begin
                s_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc       = s_q.acc;
    assign res_valid = s_q.vld;
    assign result    = s_q.res;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(result)); // R8
    AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0 && !res_valid)); // R7
endmodule

// File: rtl/gain_norm_decimator.sv
module gain_norm_decimator
    import gnd_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int RATIO    = RATIO_DEF,
    parameter int GAIN     = GAIN_DEF,
    parameter int SCALED_W = SCALED_W_DEF,
    parameter int ACC_W    = ACC_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                in_gain_hi,
    output logic                out_valid,
    output logic [ACC_W-1:0]    out_result
);
    localparam int CNT_W = $clog2(RATIO);
    localparam logic signed [ACC_W-1:0] MAX_MAG =
        ACC_W'(GAIN) * (ACC_W'(1) <<< (SAMPLE_W - 1));

    logic [SCALED_W-1:0] scaled;
    logic [CNT_W-1:0]    count;
    logic                wrap;
    logic [ACC_W-1:0]    acc;

    gnd_scaler #(
        .SAMPLE_W (SAMPLE_W),
        .SCALED_W (SCALED_W),
        .GAIN     (GAIN)
    ) u_scaler (
        .sample  (in_sample),
        .gain_hi (in_gain_hi),
        .scaled  (scaled)
    );

    gnd_block_counter #(
        .RATIO (RATIO)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (in_valid),
        .count (count),
        .wrap  (wrap)
    );

    gnd_accum #(
        .SCALED_W (SCALED_W),
        .ACC_W    (ACC_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .add_en    (in_valid),
        .wrap      (wrap),
        .addend    (scaled),
        .acc       (acc),
        .res_valid (out_valid),
        .result    (out_result)
    );

    logic signed [ACC_W-1:0] bound;
    always_comb begin
        bound = $signed({{(ACC_W-CNT_W){1'b0}}, count}) * MAX_MAG;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(acc) <= bound) && ($signed(acc) >= -bound)); // R4
    AST_PULSE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(wrap)); // R3
endmodule

// File: tb/tb_gain_norm_decimator.sv
module tb_gain_norm_decimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        in_gain_hi = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    int     m_cnt = 0;
    longint m_sum = 0;
    bit     exp_valid = 1'b0;
    longint exp_result = 0;

    always #5 clk = ~clk;

    gain_norm_decimator dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_gain_hi (in_gain_hi),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic longint scale(logic [15:0] s, logic g);
        longint v = longint'($signed(s));
        return g ? v : v * 100;
    endfunction

    task automatic check_out(string tag);
        tests++;
        if (out_valid !== exp_valid) begin
            fails++;
            $display("FAIL %s: out_valid=%0d expected %0d", tag, out_valid, exp_valid);
        end
        tests++;
        if ($signed(out_result) != exp_result) begin
            fails++;
            $display("FAIL %s: out_result=%0d expected %0d", tag, $signed(out_result), exp_result);
        end
    endtask

    // drive one cycle, then check the registered outputs at the next falling edge
    task automatic step(bit v, logic [15:0] s, bit g, bit clr, string tag);
        in_valid = v; in_sample = s; in_gain_hi = g; clear = clr;
        if (clr) begin
            m_cnt = 0; m_sum = 0; exp_valid = 1'b0;
        end else if (v) begin
            m_sum += scale(s, g);
            if (m_cnt == 71) begin
                exp_valid = 1'b1; exp_result = m_sum; m_sum = 0; m_cnt = 0;
            end else begin
                m_cnt++; exp_valid = 1'b0;
            end
        end else begin
            exp_valid = 1'b0;
        end
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic block_const(logic [15:0] s, bit g, string tag);
        for (int i = 0; i < 72; i++) step(1'b1, s, g, 1'b0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; tests++;
                $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check_out("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1");

        block_const(16'sd1, 1'b1, "R2");
        tests++; if (exp_result != 72) begin fails++; $display("FAIL R2: model=%0d expected 72", exp_result); end
        block_const(16'sd1, 1'b0, "R2");
        block_const(16'h8000, 1'b0, "R9");
        block_const(16'h7FFF, 1'b0, "R9");
        block_const(16'h8000, 1'b1, "R4");

        // partial block, then clear with a coincident sample
        for (int i = 0; i < 30; i++) step(1'b1, 16'h1234, 1'b0, 1'b0, "R7");
        step(1'b1, 16'h7FFF, 1'b0, 1'b1, "R7");
        block_const(16'sd5, 1'b1, "R7");

        // idle gaps inside a block
        for (int i = 0; i < 72; i++) begin
            step(1'b1, 16'($signed(i - 36)), i[0], 1'b0, "R6");
            step(1'b0, 16'h7FFF, 1'b0, 1'b0, "R6");
        end

        // back-to-back blocks of random codes
        for (int b = 0; b < 20; b++)
            for (int i = 0; i < 72; i++)
                step(1'b1, 16'($urandom), 1'($urandom), 1'b0, "R5");

        // random mix with gaps, clears and holds
        for (int i = 0; i < 6000; i++) begin
            bit v = ($urandom % 4) != 0;
            bit c = ($urandom % 400) == 0;
            step(v, 16'($urandom), 1'($urandom), c, "R8");
        end

        block_const(16'hFFFF, 1'b0, "R3");
        finish_run();
    end
endmodule